// File: doc/BRIEF.md
# SPI Chip-Select Routing Multiplexer

This block connects one SPI master to one of several slaves. It runs on a system clock that oversamples the master's SCLK, MOSI and CS lines. It sends SCLK and MOSI to the slave side and drives a bundle of active-low chip selects, with at most one of them low at a time. Only the selected slave's MISO is passed back to the master. When no slave is selected, or while a switch is in progress, the MISO return reads 0.

A new route can be requested at any moment through a one-cycle strobe. The request can name a slave, or "none", and it also carries the clock polarity that the slave side will use. A request is held as pending and is never applied in the middle of a transaction. The block first waits until the master's CS has been high, with SCLK resting at its idle level, for a programmed number of system clocks. It then enters a break phase. During the break every chip select is high, SCLK is parked at the idle level of the polarity in force, and MISO is gated off, for at least a programmed gap.

The new route and polarity take effect only once three conditions hold: the gap has elapsed, the master's CS is high, and SCLK rests at the new idle level. Status pins report the active route, the pending route, whether a switch is under way and whether any change is still outstanding.

The control and status pins are plain level or strobe signals. No valid/ready stream is involved and there is no back-pressure. A request strobe is always accepted, and a later strobe overwrites an earlier one that has not yet been applied. The master's SCLK high and low phases must each last at least three system clocks so that the oversampling sees every edge.

Top module: `spi_cs_router`

## Requirements
- R1: After reset all slave chip selects are high (inactive), m_miso is 0, act_en is 0, busy is 0 and s_sclk is 0 (polarity 0).
- R2: With slave k active and no switch in progress, s_cs_n[k] follows m_cs_n, every other s_cs_n bit stays 1, and s_sclk and s_mosi follow m_sclk and m_mosi, each three system clocks behind the master pin.
- R3: m_miso equals s_miso[k] while slave k is active and no switch is in progress; it is 0 when no slave is routed and throughout a switch.
- R4: A request made while m_cs_n is low or SCLK is toggling is held as pending (pend_valid 1); the active route and the forwarded chip select do not change until the transaction ends.
- R5: A request made while an earlier one is still pending replaces it, and only the newest request is applied.
- R6: A pending request enters the switch phase only after m_cs_n has been high, with SCLK at the current idle level, for at least cfg_idle_cnt system clocks.
- R7: The switch phase (sw_active 1) lasts at least cfg_gap_cnt+1 system clocks, and all s_cs_n bits are 1 throughout it.
- R8: s_sclk is held at the idle level of the polarity in force during a switch and whenever no slave is routed.
- R9: A request's polarity bit (0: SCLK idles low, 1: SCLK idles high) becomes cur_cpol when the route is applied. Application waits until the master's SCLK rests at that new level.
- R10: act_en/act_slave report the applied route, and pend_valid/pend_en/pend_slave report the pending one from the cycle after the request strobe. Request field req_en=0 means "no slave".
- R11: At most one s_cs_n bit is low at any time.
- R12: A route is not reopened while m_cs_n is low; the switch phase is extended until the master's CS returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_idle_cnt | input | CNT_W | Idle clocks required before a switch may start |
| cfg_gap_cnt | input | CNT_W | Minimum all-deselected gap, in system clocks |
| req_stb | input | 1 | One-cycle strobe capturing a route request |
| req_en | input | 1 | 1: route to req_slave, 0: select no slave |
| req_slave | input | SEL_W | Slave index requested |
| req_cpol | input | 1 | SCLK idle level for the requested route |
| m_sclk | input | 1 | Master SCLK |
| m_mosi | input | 1 | Master MOSI |
| m_cs_n | input | 1 | Master chip select, active low |
| m_miso | output | 1 | MISO returned to the master |
| s_sclk | output | 1 | SCLK to the slaves |
| s_mosi | output | 1 | MOSI to the slaves |
| s_cs_n | output | N_SLV | Per-slave chip selects, active low |
| s_miso | input | N_SLV | MISO from each slave |
| act_en | output | 1 | A slave is currently routed |
| act_slave | output | SEL_W | Index of the routed slave |
| cur_cpol | output | 1 | SCLK idle level in force |
| pend_valid | output | 1 | A request awaits application |
| pend_en | output | 1 | Pending request selects a slave |
| pend_slave | output | SEL_W | Pending slave index |
| busy | output | 1 | A switch is pending or in progress |
| sw_active | output | 1 | Break phase in progress |

## Verification
The bench builds the block with four slaves and 8-bit counters. It changes the idle requirement between 3 and 20 clocks and the gap between 4 and 10 clocks at run time. This lets it measure the idle wait against a long threshold and watch a break that outlasts its gap while the master holds CS low. Four slaves give a full two-bit index, so the vectors can check one-hot chip-select patterns, MISO from a high index, and a change of polarity to an SCLK level that idles high.

// File: rtl/spi_route_pkg.sv
package spi_route_pkg;

  typedef enum logic {
    ST_OPEN  = 1'b0,
    ST_BREAK = 1'b1
  } route_st_e;

  localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int                W       = 3,
  parameter int                STAGES  = 2,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_idle_detect.sv
module spi_idle_detect #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_hi,
  input  logic             sclk_lvl,
  input  logic             cur_cpol,
  input  logic [CNT_W-1:0] cfg_idle_cnt,
  output logic             bus_idle
);
  logic [CNT_W-1:0] quiet_cnt;
  logic             quiet_now;

  assign quiet_now = cs_hi && (sclk_lvl == cur_cpol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_cnt <= '0;
    end else if (quiet_now) begin
      if (quiet_cnt != '1) quiet_cnt <= quiet_cnt + 1'b1;
    end else begin
      quiet_cnt <= '0;
    end
  end

  assign bus_idle = quiet_now && (quiet_cnt >= cfg_idle_cnt);
endmodule

// File: rtl/spi_route_ctrl.sv
module spi_route_ctrl
  import spi_route_pkg::*;
#(
  parameter int N_SLV = 4,
  parameter int SEL_W = 2,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_stb,
  input  logic             req_en,
  input  logic [SEL_W-1:0] req_slave,
  input  logic             req_cpol,
  input  logic             bus_idle,
  input  logic             cs_hi,
  input  logic             sclk_lvl,
  input  logic [CNT_W-1:0] cfg_gap_cnt,
  output logic             act_en,
  output logic [SEL_W-1:0] act_slave,
  output logic             cur_cpol,
  output logic             pend_valid,
  output logic             pend_en,
  output logic [SEL_W-1:0] pend_slave,
  output logic             in_break
);
  route_st_e        state;
  logic             pend_cpol;
  logic [CNT_W-1:0] gap_cnt;
  logic             gap_done;
  logic             apply;
  logic             req_in_range;

  assign req_in_range = (int'(req_slave) < N_SLV);
  assign in_break     = (state == ST_BREAK);
  assign gap_done     = (gap_cnt >= cfg_gap_cnt);
  assign apply        = in_break && gap_done && cs_hi && (sclk_lvl == pend_cpol);

  // switch sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_OPEN;
      gap_cnt   <= '0;
      act_en    <= 1'b0;
      act_slave <= '0;
      cur_cpol  <= 1'b0;
    end else begin
      case (state)
        ST_OPEN: begin
          if (pend_valid && bus_idle) begin
            state   <= ST_BREAK;
            gap_cnt <= '0;
          end
        end
        ST_BREAK: begin
          if (gap_cnt != '1) gap_cnt <= gap_cnt + 1'b1;
          if (apply) begin
            state     <= ST_OPEN;
            act_en    <= pend_en;
            act_slave <= pend_slave;
            cur_cpol  <= pend_cpol;
          end
        end
        default: state <= ST_OPEN;
      endcase
    end
  end

  // pending request holder, newest wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_en    <= 1'b0;
      pend_slave <= '0;
      pend_cpol  <= 1'b0;
    end else if (req_stb) begin
      pend_valid <= 1'b1;
      pend_en    <= req_en && req_in_range;
      pend_slave <= req_slave;
      pend_cpol  <= req_cpol;
    end else if (apply) begin
      pend_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_cs_router.sv
module spi_cs_router
  import spi_route_pkg::*;
#(
  parameter int N_SLV = 4,
  parameter int CNT_W = 8,
  localparam int SEL_W = (N_SLV > 1) ? $clog2(N_SLV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_idle_cnt,
  input  logic [CNT_W-1:0] cfg_gap_cnt,
  input  logic             req_stb,
  input  logic             req_en,
  input  logic [SEL_W-1:0] req_slave,
  input  logic             req_cpol,
  input  logic             m_sclk,
  input  logic             m_mosi,
  input  logic             m_cs_n,
  output logic             m_miso,
  output logic             s_sclk,
  output logic             s_mosi,
  output logic [N_SLV-1:0] s_cs_n,
  input  logic [N_SLV-1:0] s_miso,
  output logic             act_en,
  output logic [SEL_W-1:0] act_slave,
  output logic             cur_cpol,
  output logic             pend_valid,
  output logic             pend_en,
  output logic [SEL_W-1:0] pend_slave,
  output logic             busy,
  output logic             sw_active
);
  logic sclk_s, mosi_s, cs_s;
  logic bus_idle;
  logic in_break;
  logic fwd;

  spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({m_cs_n, m_sclk, m_mosi}),
    .q     ({cs_s, sclk_s, mosi_s})
  );

  spi_idle_detect #(.CNT_W(CNT_W)) u_idle (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_hi        (cs_s),
    .sclk_lvl     (sclk_s),
    .cur_cpol     (cur_cpol),
    .cfg_idle_cnt (cfg_idle_cnt),
    .bus_idle     (bus_idle)
  );

  spi_route_ctrl #(.N_SLV(N_SLV), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_stb     (req_stb),
    .req_en      (req_en),
    .req_slave   (req_slave),
    .req_cpol    (req_cpol),
    .bus_idle    (bus_idle),
    .cs_hi       (cs_s),
    .sclk_lvl    (sclk_s),
    .cfg_gap_cnt (cfg_gap_cnt),
    .act_en      (act_en),
    .act_slave   (act_slave),
    .cur_cpol    (cur_cpol),
    .pend_valid  (pend_valid),
    .pend_en     (pend_en),
    .pend_slave  (pend_slave),
    .in_break    (in_break)
  );

  assign fwd       = act_en && !in_break;
  assign busy      = in_break || pend_valid;
  assign sw_active = in_break;

  // per-slave chip-select drivers
  for (genvar i = 0; i < N_SLV; i++) begin : g_cs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_cs_n[i] <= 1'b1;
      else        s_cs_n[i] <= (fwd && (int'(act_slave) == i)) ? cs_s : 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sclk <= 1'b0;
      s_mosi <= 1'b0;
    end else begin
      s_sclk <= fwd ? sclk_s : cur_cpol;
      s_mosi <= fwd ? mosi_s : 1'b0;
    end
  end

  assign m_miso = fwd ? s_miso[act_slave] : 1'b0;
endmodule

// File: rtl/spi_cs_router_chk.sv
module spi_cs_router_chk #(
  parameter int N_SLV = 4,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SLV-1:0] s_cs_n,
  input logic             s_sclk,
  input logic             m_miso,
  input logic             act_en,
  input logic [SEL_W-1:0] act_slave,
  input logic             in_break,
  input logic             cur_cpol
);
  // R11: never two slaves selected
  p_cs_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~s_cs_n) <= 1);

  // R3: no return path without a route
  p_miso_none_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en |-> !m_miso);

  // R7: every select inactive during the break
  p_break_cs_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_break |=> &s_cs_n);

  // R8: SCLK parked at the idle level during a switch
  p_sclk_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_break |=> (s_sclk == $past(cur_cpol)));

  // R4: route changes only out of a break
  p_route_via_break_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({act_en, act_slave}) |-> $past(in_break));

  // R9: polarity changes only out of a break
  p_cpol_via_break_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_cpol) |-> $past(in_break));
endmodule

bind spi_cs_router spi_cs_router_chk #(.N_SLV(N_SLV), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_cs_n    (s_cs_n),
  .s_sclk    (s_sclk),
  .m_miso    (m_miso),
  .act_en    (act_en),
  .act_slave (act_slave),
  .in_break  (in_break),
  .cur_cpol  (cur_cpol)
);

// File: tb/spi_cs_router_bench.sv
module spi_cs_router_bench;
  localparam int N_SLV = 4;
  localparam int CNT_W = 8;
  localparam int SEL_W = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] cfg_idle_cnt = 8'd3;
  logic [CNT_W-1:0] cfg_gap_cnt = 8'd4;
  logic             req_stb = 1'b0, req_en = 1'b0, req_cpol = 1'b0;
  logic [SEL_W-1:0] req_slave = '0;
  logic             m_sclk = 1'b0, m_mosi = 1'b0, m_cs_n = 1'b1;
  logic             m_miso, s_sclk, s_mosi;
  logic [N_SLV-1:0] s_cs_n;
  logic [N_SLV-1:0] s_miso = '0;
  logic             act_en, cur_cpol, pend_valid, pend_en, busy, sw_active;
  logic [SEL_W-1:0] act_slave, pend_slave;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  spi_cs_router #(.N_SLV(N_SLV), .CNT_W(CNT_W)) u_spi_cs_router (.*);

  // {cs, sclk, mosi, miso[3:0], exp_cs_n[3:0], exp_sclk, exp_mosi, exp_miso}, slave 2 routed
  localparam logic [13:0] VEC [6] = '{
    {3'b100, 4'b0000, 4'b1111, 3'b000},
    {3'b001, 4'b0100, 4'b1011, 3'b011},
    {3'b010, 4'b0100, 4'b1011, 3'b101},
    {3'b011, 4'b1011, 4'b1011, 3'b110},
    {3'b000, 4'b1111, 4'b1011, 3'b001},
    {3'b101, 4'b0000, 4'b1111, 3'b010}
  };

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request(input bit en, input int slv, input bit pol);
    req_stb = 1'b1; req_en = en; req_slave = SEL_W'(slv); req_cpol = pol;
    @(negedge clk);
    req_stb = 1'b0;
  endtask

  task automatic wait_open(input string rq);
    int k = 0;
    while (busy && k < 500) begin @(negedge clk); k++; end
    chk(!busy, rq, int'(busy), 0);
  endtask

  task automatic wait_sw(input string rq);
    int k = 0;
    while (!sw_active && k < 200) begin @(negedge clk); k++; end
    chk(sw_active, rq, int'(sw_active), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int sw_cyc;
    int wait_cyc;
    bit cs_ok;
    s_miso = 4'b1111;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk(s_cs_n == 4'b1111, "R1 cs", s_cs_n, 15);
    chk(m_miso == 1'b0, "R1 miso", m_miso, 0);
    chk(!act_en && !busy, "R1 status", {act_en, busy}, 0);
    chk(s_sclk == 1'b0, "R1 sclk", s_sclk, 0);

    // R10 / R7: first route, slave 2
    request(1'b1, 2, 1'b0);
    chk(pend_valid && pend_en && pend_slave == 2, "R10 pending", pend_slave, 2);
    sw_cyc = 0; cs_ok = 1'b1;
    for (int k = 0; k < 200 && busy; k++) begin
      if (sw_active) sw_cyc++;
      if (s_cs_n != 4'b1111) cs_ok = 1'b0;
      @(negedge clk);
    end
    chk(sw_cyc >= 5, "R7 gap length", sw_cyc, 5);
    chk(cs_ok, "R7 cs high in gap", cs_ok, 1);
    chk(act_en && act_slave == 2, "R10 active", act_slave, 2);

    // vector table: R2 forwarding, R3 return
    foreach (VEC[i]) begin
      {m_cs_n, m_sclk, m_mosi, s_miso} = VEC[i][13:7];
      cyc(4);
      chk(s_cs_n == VEC[i][6:3], "R2 cs", s_cs_n, VEC[i][6:3]);
      chk(s_sclk == VEC[i][2] && s_mosi == VEC[i][1], "R2 sclk/mosi",
          {s_sclk, s_mosi}, VEC[i][2:1]);
      chk(m_miso == VEC[i][0], "R3 miso", m_miso, VEC[i][0]);
    end

    // R4 / R5: requests during a transaction
    m_cs_n = 1'b0; m_sclk = 1'b0;
    cyc(3);
    request(1'b1, 3, 1'b0);
    chk(pend_valid && act_slave == 2, "R4 latched", act_slave, 2);
    for (int k = 0; k < 10; k++) begin m_sclk = ~m_sclk; cyc(3); end
    chk(act_slave == 2 && s_cs_n == 4'b1011, "R4 held", s_cs_n, 11);
    request(1'b1, 0, 1'b0);
    chk(pend_slave == 0, "R5 replaced", pend_slave, 0);
    m_sclk = 1'b0; m_cs_n = 1'b1;
    wait_open("R5 open");
    chk(act_slave == 0 && act_en, "R5 newest applied", act_slave, 0);

    // R6: long idle requirement
    cfg_idle_cnt = 8'd20;
    m_cs_n = 1'b0; cyc(3); m_cs_n = 1'b1;
    request(1'b1, 1, 1'b0);
    wait_cyc = 1;
    while (!sw_active && wait_cyc < 100) begin @(negedge clk); wait_cyc++; end
    chk(wait_cyc >= 20 && wait_cyc <= 30, "R6 idle wait", wait_cyc, 23);
    wait_open("R6 open");
    chk(act_slave == 1, "R6 applied", act_slave, 1);
    cfg_idle_cnt = 8'd3;

    // R9 / R8 / R3: polarity change to idle-high
    s_miso = 4'b1111;
    request(1'b1, 1, 1'b1);
    wait_sw("R9 enter switch");
    chk(m_miso == 1'b0, "R3 gated in switch", m_miso, 0);
    m_sclk = 1'b1;
    cyc(2);
    chk(sw_active && s_sclk == 1'b0, "R8 parked old level", s_sclk, 0);
    wait_open("R9 open");
    cyc(3);
    chk(cur_cpol == 1'b1 && s_sclk == 1'b1, "R9 new idle level", {cur_cpol, s_sclk}, 3);
    m_cs_n = 1'b0; cyc(4);
    chk(s_cs_n == 4'b1101, "R2 slave1 select", s_cs_n, 13);
    m_cs_n = 1'b1; cyc(4);

    // R12: master starts a transaction during the break
    cfg_gap_cnt = 8'd10;
    request(1'b1, 3, 1'b1);
    wait_sw("R12 enter switch");
    m_cs_n = 1'b0;
    cyc(20);
    chk(sw_active && s_cs_n == 4'b1111, "R12 held closed", s_cs_n, 15);
    m_cs_n = 1'b1;
    wait_open("R12 open");
    chk(act_slave == 3, "R12 applied", act_slave, 3);

    // R8 / R10: route to no slave
    request(1'b0, 0, 1'b1);
    wait_open("R10 none open");
    m_cs_n = 1'b0; m_sclk = 1'b0;
    cyc(4);
    chk(!act_en, "R10 none active", act_en, 0);
    chk(s_cs_n == 4'b1111 && m_miso == 1'b0, "R3 none gated", {s_cs_n, m_miso}, 30);
    chk(s_sclk == 1'b1, "R8 parked no route", s_sclk, 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule